// File: doc/BRIEF.md
# Static Operand Switch

This block is the router of one tile in a two-dimensional mesh that carries scalar operands between neighbouring processors. It has five operand ports: the four mesh neighbours (north, east, south, west) and the local processor. Traffic does not carry a header. Where each operand goes is fixed ahead of time by a per-tile program of route instructions. A small sequencer steps through that program, and a crossbar joins sources to destinations as each instruction asks. Every port, inbound and outbound, uses valid/ready flow control. An operand crosses the tile in one clock cycle.

Software loads the program through a write port while the sequencer is idle or halted. It then pulses `start`. The sequencer has three states:

- `SEQ_IDLE`: the reset state. It moves to `SEQ_RUN` on `start`, but only once at least one word has been loaded.
- `SEQ_RUN`: the state in which instructions execute.
- `SEQ_HALT`: entered when the halt word is fetched. It moves back to `SEQ_RUN` on `start`, beginning again at address 0.

Each instruction retires as a whole or not at all. The program counter returns to zero after the highest address that was written.

Top module: `static_operand_switch`

## Requirements
- R1: After reset every `out_valid` bit is 0 and every `in_ready` bit is 1. No operand is routed until a program is loaded and `start` is pulsed.
- R2: An instruction is 15 bits wide and holds one 3-bit source field per output. The field for output o sits at bits [3o+2:3o], with outputs indexed N=0, E=1, S=2, W=3, P=4. Source codes are 0 none, 1 N, 2 E, 3 S, 4 W and 5 P. Code 6, and code 7 outside the halt word, mean no route.
- R3: Fetching the halt word 15'h7FFF moves the sequencer to `SEQ_HALT`, where no transfer takes place. A later `start` resumes execution from address 0.
- R4: An operand offered on an input in cycle t, whose instruction can retire in that cycle, is valid on its output in cycle t+1.
- R5: An instruction retires only when every source it names holds an operand and every output it drives is free, meaning that output is empty or is being accepted. Until then, no output of that instruction is loaded and no source is consumed.
- R6: One instruction may send a single source to several outputs. That source operand is consumed once.
- R7: Each input buffers up to two operands in arrival order. Its `in_ready` is low while two are held.
- R8: While `out_valid` is high and `out_ready` is low, the output keeps its valid bit and its data unchanged.
- R9: After the instruction at the highest written address retires, the next instruction fetched is the one at address 0.
- R10: Program writes are ignored in `SEQ_RUN`. A `start` pulse is ignored in `SEQ_IDLE` while nothing has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Program word write strobe |
| prog_addr | input | 6 | Program word address |
| prog_data | input | 15 | Program word |
| start | input | 1 | Begin or resume execution at address 0 |
| in_valid | input | 5 | Operand offered, one bit per input (N,E,S,W,P) |
| in_data | input | 160 | Operand values, 32 bits per input, N in the low bits |
| in_ready | output | 5 | Input can accept an operand |
| out_valid | output | 5 | Operand present, one bit per output |
| out_data | output | 160 | Output operand values, 32 bits per output |
| out_ready | input | 5 | Downstream accepts the output operand |

## Verification
The bench targets the following corner cases, each with the failure it would expose:

- **Half-ready instruction.** A switch that commits partial transfers would emit one operand early and lose its pairing.
- **Fan-out.** A switch that consumed the source once per destination would fire again with stale or missing data.
- **Full input buffer under a stalled output.** A switch that let `in_ready` stay high would drop or reorder operands.
- **Halt, restart and wrap.** Errors here show up as routes going to the wrong port on later cycles.
- **Start before any load, and writes during a run.** A switch that accepted these would move data it should not.

// File: rtl/ssw_pkg.sv
package ssw_pkg;

    localparam int NPORT   = 5;
    localparam int FIELD_W = 3;
    localparam int INSTR_W = NPORT * FIELD_W;

    // port index order: N=0, E=1, S=2, W=3, P=4; source code = index + 1
    localparam logic [FIELD_W-1:0] CODE_NONE = 3'd0;
    localparam logic [FIELD_W-1:0] CODE_LAST = 3'd5;
    localparam logic [INSTR_W-1:0] HALT_WORD = '1;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_RUN,
        SEQ_HALT
    } seq_state_e;

    function automatic logic code_routes(input logic [FIELD_W-1:0] code);
        return (code != CODE_NONE) && (code <= CODE_LAST);
    endfunction

endpackage

// File: rtl/ssw_fifo.sv
module ssw_fifo #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              pop,
    output logic              head_valid,
    output logic [DATA_W-1:0] head_data
);

    logic [1:0]        cnt;
    logic [DATA_W-1:0] e0, e1;
    logic              push;

    assign in_ready   = (cnt != 2'd2);
    assign push       = in_valid && in_ready;
    assign head_valid = (cnt != 2'd0) || in_valid;
    assign head_data  = (cnt != 2'd0) ? e0 : in_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 2'd0;
            e0  <= '0;
            e1  <= '0;
        end else begin
            unique case (cnt)
                2'd0: begin
                    if (push && !pop) begin
                        e0  <= in_data;
                        cnt <= 2'd1;
                    end
                end
                2'd1: begin
                    if (push && pop) begin
                        e0 <= in_data;
                    end else if (pop) begin
                        cnt <= 2'd0;
                    end else if (push) begin
                        e1  <= in_data;
                        cnt <= 2'd2;
                    end
                end
                2'd2: begin
                    if (pop) begin
                        e0  <= e1;
                        cnt <= 2'd1;
                    end
                end
                default: cnt <= 2'd0;
            endcase
        end
    end

    // the crossbar must never consume an operand that is not there
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);

    // a full buffer keeps refusing until something leaves
    assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !pop) |=> !in_ready);

endmodule

// File: rtl/ssw_xbar.sv
module ssw_xbar
    import ssw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [INSTR_W-1:0]      instr,
    input  logic                    run,
    input  logic [NPORT-1:0]        head_valid,
    input  logic [NPORT*DATA_W-1:0] head_data,
    input  logic [NPORT-1:0]        slot_free,
    output logic                    fire,
    output logic [NPORT-1:0]        pop,
    output logic [NPORT-1:0]        load,
    output logic [NPORT*DATA_W-1:0] load_data
);

    logic [NPORT-1:0] need;
    logic [NPORT-1:0] used;
    logic             all_ok;

    always_comb begin
        need      = '0;
        used      = '0;
        all_ok    = 1'b1;
        load_data = '0;
        for (int o = 0; o < NPORT; o++) begin
            logic [FIELD_W-1:0] code;
            int src;
            code = instr[o*FIELD_W +: FIELD_W];
            src  = int'(code) - 1;
            if (code_routes(code)) begin
                need[o] = 1'b1;
                used[src] = 1'b1;
                load_data[o*DATA_W +: DATA_W] = head_data[src*DATA_W +: DATA_W];
                if (!(head_valid[src] && slot_free[o])) begin
                    all_ok = 1'b0;
                end
            end
        end
        fire = run && (instr != HALT_WORD) && all_ok;
        load = need & {NPORT{fire}};
        pop  = used & {NPORT{fire}};
    end

endmodule

// File: rtl/ssw_seq.sv
module ssw_seq
    import ssw_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_we,
    input  logic [AW-1:0]      prog_addr,
    input  logic [INSTR_W-1:0] prog_data,
    input  logic               start,
    input  logic               fire,
    output logic [INSTR_W-1:0] instr,
    output logic               run
);

    seq_state_e         state, state_n;
    logic [INSTR_W-1:0] mem [DEPTH];
    logic [AW-1:0]      pc;
    logic [AW-1:0]      last_idx;
    logic               loaded;
    logic               wr_ok;
    logic               restart;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_n;
    end

    // next state and outputs
    always_comb begin
        state_n = state;
        restart = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                if (start && loaded) begin
                    state_n = SEQ_RUN;
                    restart = 1'b1;
                end
            end
            SEQ_RUN: begin
                if (instr == HALT_WORD) state_n = SEQ_HALT;
            end
            SEQ_HALT: begin
                if (start) begin
                    state_n = SEQ_RUN;
                    restart = 1'b1;
                end
            end
            default: state_n = SEQ_IDLE;
        endcase
        run   = (state == SEQ_RUN);
        wr_ok = (state != SEQ_RUN);
        instr = mem[pc];
    end

    // program store, limit and counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            pc       <= '0;
            last_idx <= '0;
            loaded   <= 1'b0;
        end else begin
            if (prog_we && wr_ok) begin
                mem[prog_addr] <= prog_data;
                loaded         <= 1'b1;
                if (!loaded || prog_addr > last_idx) last_idx <= prog_addr;
            end
            if (restart) begin
                pc <= '0;
            end else if (fire) begin
                pc <= (pc == last_idx) ? '0 : pc + AW'(1);
            end
        end
    end

    assert_quiet_unless_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SEQ_RUN) |-> !fire);

    assert_halt_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RUN && instr == HALT_WORD) |=> (state == SEQ_HALT && $stable(pc)));

    assert_pc_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RUN) |-> (pc <= last_idx));

endmodule

// File: rtl/static_operand_switch.sv
module static_operand_switch
    import ssw_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int PROG_DEPTH = 64,
    localparam int AW        = $clog2(PROG_DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    prog_we,
    input  logic [AW-1:0]           prog_addr,
    input  logic [INSTR_W-1:0]      prog_data,
    input  logic                    start,
    input  logic [NPORT-1:0]        in_valid,
    input  logic [NPORT*DATA_W-1:0] in_data,
    output logic [NPORT-1:0]        in_ready,
    output logic [NPORT-1:0]        out_valid,
    output logic [NPORT*DATA_W-1:0] out_data,
    input  logic [NPORT-1:0]        out_ready
);

    logic [INSTR_W-1:0]      instr;
    logic                    run;
    logic                    fire;
    logic [NPORT-1:0]        head_valid;
    logic [NPORT*DATA_W-1:0] head_data;
    logic [NPORT-1:0]        slot_free;
    logic [NPORT-1:0]        pop;
    logic [NPORT-1:0]        load;
    logic [NPORT*DATA_W-1:0] load_data;

    ssw_seq #(.DEPTH(PROG_DEPTH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .start     (start),
        .fire      (fire),
        .instr     (instr),
        .run       (run)
    );

    ssw_xbar #(.DATA_W(DATA_W)) u_xbar (
        .instr      (instr),
        .run        (run),
        .head_valid (head_valid),
        .head_data  (head_data),
        .slot_free  (slot_free),
        .fire       (fire),
        .pop        (pop),
        .load       (load),
        .load_data  (load_data)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        ssw_fifo #(.DATA_W(DATA_W)) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid   (in_valid[p]),
            .in_data    (in_data[p*DATA_W +: DATA_W]),
            .in_ready   (in_ready[p]),
            .pop        (pop[p]),
            .head_valid (head_valid[p]),
            .head_data  (head_data[p*DATA_W +: DATA_W])
        );

        assign slot_free[p] = !out_valid[p] || out_ready[p];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid[p]                  <= 1'b0;
                out_data[p*DATA_W +: DATA_W]  <= '0;
            end else if (load[p]) begin
                out_valid[p]                  <= 1'b1;
                out_data[p*DATA_W +: DATA_W]  <= load_data[p*DATA_W +: DATA_W];
            end else if (out_ready[p]) begin
                out_valid[p]                  <= 1'b0;
            end
        end

        assert_atomic_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
            load[p] |-> slot_free[p]);

        assert_one_hop_R4: assert property (@(posedge clk) disable iff (!rst_n)
            load[p] |=> out_valid[p]);

        assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[p] && !out_ready[p]) |=>
                (out_valid[p] && $stable(out_data[p*DATA_W +: DATA_W])));
    end

endmodule

// File: tb/sim_static_operand_switch.sv
module sim_static_operand_switch;

    localparam int NP = 5;
    localparam int DW = 32;
    localparam logic [2:0] CN = 3'd0, CSN = 3'd1, CSE = 3'd2, CSS = 3'd3, CSW = 3'd4, CSP = 3'd5;
    localparam int PN = 0, PE = 1, PS = 2, PW = 3, PP = 4;

    // stimulus vectors: {all-ports-valid, seed}; expected: outputs valid iff bit 32 set
    localparam logic [32:0] VEC [8] = '{
        {1'b1, 32'h0000_0001}, {1'b1, 32'hDEAD_BEEF}, {1'b0, 32'h1234_5678},
        {1'b1, 32'hFFFF_FFFF}, {1'b1, 32'h8000_0000}, {1'b0, 32'h0F0F_0F0F},
        {1'b1, 32'hA5A5_5A5A}, {1'b1, 32'h0000_0000}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            prog_we = 1'b0;
    logic [5:0]      prog_addr = '0;
    logic [14:0]     prog_data = '0;
    logic            start = 1'b0;
    logic [NP-1:0]   in_valid = '0;
    logic [NP*DW-1:0] in_data = '0;
    logic [NP-1:0]   in_ready;
    logic [NP-1:0]   out_valid;
    logic [NP*DW-1:0] out_data;
    logic [NP-1:0]   out_ready = '1;

    int ntot = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    static_operand_switch u0 (
        .clk (clk), .rst_n (rst_n), .prog_we (prog_we), .prog_addr (prog_addr),
        .prog_data (prog_data), .start (start), .in_valid (in_valid), .in_data (in_data),
        .in_ready (in_ready), .out_valid (out_valid), .out_data (out_data), .out_ready (out_ready)
    );

    function automatic logic [14:0] mk(input logic [2:0] n, e, s, w, p);
        return {p, w, s, e, n};
    endfunction

    function automatic logic [31:0] od(input int p);
        return out_data[p*DW +: DW];
    endfunction

    function automatic logic [31:0] pd(input logic [31:0] seed, input int p);
        return seed ^ (32'(p) * 32'h0101_0101);
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        ntot++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = '0; start = 1'b0; prog_we = 1'b0; out_ready = '1;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic ld(input int a, input logic [14:0] w);
        prog_we = 1'b1; prog_addr = 6'(a); prog_data = w;
        step();
        prog_we = 1'b0;
    endtask

    task automatic go();
        start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic put(input int p, input logic [31:0] d);
        in_valid[p] = 1'b1;
        in_data[p*DW +: DW] = d;
    endtask

    initial begin
        #2_000_000;
        ntot++; nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", ntot - nfail, ntot);
        $finish;
    end

    initial begin
        // ---- table walk: rotating program, all routes in one instruction (R2, R4, R9)
        do_reset();
        ld(0, mk(CSP, CSN, CSE, CSS, CSW));
        go();
        for (int i = 0; i < 8; i++) begin
            in_valid = {NP{VEC[i][32]}};
            for (int p = 0; p < NP; p++) in_data[p*DW +: DW] = pd(VEC[i][31:0], p);
            step();
            in_valid = '0;
            chk(out_valid == {NP{VEC[i][32]}}, "R4 vector valid", 64'(out_valid), 64'({NP{VEC[i][32]}}));
            if (VEC[i][32]) begin
                for (int o = 0; o < NP; o++) begin
                    chk(od(o) == pd(VEC[i][31:0], (o + 4) % 5), "R2 vector route",
                        64'(od(o)), 64'(pd(VEC[i][31:0], (o + 4) % 5)));
                end
            end
        end

        // ---- R1 reset state, R10 start before load
        do_reset();
        chk(out_valid == '0, "R1 out_valid after reset", 64'(out_valid), 0);
        chk(in_ready == '1, "R1 in_ready after reset", 64'(in_ready), 64'h1F);
        go();
        put(PN, 32'hCAFE_0001);
        step();
        in_valid = '0;
        ld(0, mk(CN, CSN, CN, CN, CN));
        repeat (3) step();
        chk(out_valid == '0, "R10 start ignored before load", 64'(out_valid), 0);
        go();
        step();
        chk(out_valid == 5'b00010 && od(PE) == 32'hCAFE_0001, "R10 buffered operand after start",
            64'(od(PE)), 64'hCAFE_0001);

        // ---- R10 writes during run ignored
        ld(0, mk(CN, CN, CN, CSP, CN));
        put(PN, 32'h0000_0A0A);
        put(PP, 32'h0000_0B0B);
        step();
        in_valid = '0;
        chk(out_valid == 5'b00010 && od(PE) == 32'h0000_0A0A, "R10 program unchanged in run",
            64'(out_valid), 64'h02);

        // ---- R5 atomic: E<-N and S<-W together
        do_reset();
        ld(0, mk(CN, CSN, CSW, CN, CN));
        go();
        put(PN, 32'h1111_0000);
        step();
        in_valid = '0;
        chk(out_valid == '0, "R5 no partial transfer", 64'(out_valid), 0);
        step();
        chk(out_valid == '0, "R5 still waiting", 64'(out_valid), 0);
        put(PW, 32'h2222_0000);
        step();
        in_valid = '0;
        chk(out_valid == 5'b00110, "R5 both outputs together", 64'(out_valid), 64'h06);
        chk(od(PE) == 32'h1111_0000 && od(PS) == 32'h2222_0000, "R5 data pairing",
            {od(PE), od(PS)}, {32'h1111_0000, 32'h2222_0000});

        // ---- R6 fan-out of P to N, E, S
        do_reset();
        ld(0, mk(CSP, CSP, CSP, CN, CN));
        go();
        put(PP, 32'h0F0F_1234);
        step();
        in_valid = '0;
        chk(out_valid == 5'b00111, "R6 fan-out valid", 64'(out_valid), 64'h07);
        chk(od(PN) == 32'h0F0F_1234 && od(PE) == 32'h0F0F_1234 && od(PS) == 32'h0F0F_1234,
            "R6 fan-out data", 64'(od(PS)), 64'h0F0F_1234);
        step();
        chk(out_valid == '0, "R6 source consumed once", 64'(out_valid), 0);

        // ---- R2 code 6 means no route
        do_reset();
        ld(0, mk(CN, 3'd6, CSN, CN, CN));
        go();
        put(PN, 32'h6666_0006);
        step();
        in_valid = '0;
        chk(out_valid == 5'b00100 && od(PS) == 32'h6666_0006, "R2 code 6 unrouted", 64'(out_valid), 64'h04);

        // ---- R7 buffering and R8 stall hold
        do_reset();
        ld(0, mk(CN, CSN, CN, CN, CN));
        go();
        out_ready[PE] = 1'b0;
        put(PN, 32'h0000_00A0);
        step();
        chk(out_valid[PE] && od(PE) == 32'h0000_00A0, "R4 first word out", 64'(od(PE)), 64'hA0);
        put(PN, 32'h0000_00A1);
        step();
        put(PN, 32'h0000_00A2);
        step();
        in_valid = '0;
        chk(in_ready[PN] == 1'b0, "R7 in_ready low when two held", 64'(in_ready[PN]), 0);
        step();
        step();
        chk(out_valid[PE] && od(PE) == 32'h0000_00A0, "R8 held under stall", 64'(od(PE)), 64'hA0);
        out_ready[PE] = 1'b1;
        step();
        chk(out_valid[PE] && od(PE) == 32'h0000_00A1, "R7 order second", 64'(od(PE)), 64'hA1);
        step();
        chk(out_valid[PE] && od(PE) == 32'h0000_00A2, "R7 order third", 64'(od(PE)), 64'hA2);
        step();
        chk(!out_valid[PE] && in_ready[PN], "R7 drained", 64'({out_valid[PE], in_ready[PN]}), 64'h1);

        // ---- R3 halt and restart
        do_reset();
        ld(0, mk(CN, CSN, CN, CN, CN));
        ld(1, 15'h7FFF);
        go();
        put(PN, 32'h0000_0C01);
        step();
        chk(out_valid[PE] && od(PE) == 32'h0000_0C01, "R3 before halt", 64'(od(PE)), 64'hC01);
        put(PN, 32'h0000_0C02);
        step();
        in_valid = '0;
        chk(!out_valid[PE], "R3 halted no transfer", 64'(out_valid), 0);
        repeat (3) step();
        chk(out_valid == '0, "R3 stays halted", 64'(out_valid), 0);
        go();
        step();
        chk(out_valid[PE] && od(PE) == 32'h0000_0C02, "R3 resume at address 0", 64'(od(PE)), 64'hC02);

        // ---- R9 wrap after highest written address
        do_reset();
        ld(0, mk(CN, CSN, CN, CN, CN));
        ld(1, mk(CN, CN, CSN, CN, CN));
        ld(2, mk(CN, CN, CN, CSN, CN));
        go();
        put(PN, 32'h9000_0000);
        step();
        chk(out_valid == 5'b00010, "R9 step 0 to E", 64'(out_valid), 64'h02);
        put(PN, 32'h9000_0001);
        step();
        chk(out_valid == 5'b00100, "R9 step 1 to S", 64'(out_valid), 64'h04);
        put(PN, 32'h9000_0002);
        step();
        chk(out_valid == 5'b01000, "R9 step 2 to W", 64'(out_valid), 64'h08);
        put(PN, 32'h9000_0003);
        step();
        in_valid = '0;
        chk(out_valid == 5'b00010 && od(PE) == 32'h9000_0003, "R9 wrapped to E", 64'(od(PE)), 64'h9000_0003);

        $display("%0d/%0d checks passed", ntot - nfail, ntot);
        $finish;
    end

endmodule